// File: doc/BRIEF.md
# Two-Tier Rotational Secondary Bus Arbiter

This block decides which initiator may drive the secondary side of a bus bridge. It serves one internal requester, which is the bridge itself, and a parameterised number of external request/grant pairs. The default is nine pairs, giving ten masters in all. Each master sits in either the high or the low priority tier, as set by a per-master tier register. The high tier rotates round-robin over its members plus one extra slot. That extra slot stands for the entire low tier, and the low tier rotates round-robin among its own members each time the slot comes up. The grant moves only while the bus is idle. With nothing pending, the grant rests on the bridge.

A static strap selects an external arbiter instead. In that mode the grant outputs of pairs 1 and up stop driving, and pair 0 is reused as the bridge's own link to the outside arbiter. Its grant pin carries the bridge's request outward, and its request pin carries the outside grant inward. All signals are active high. Master index 0 is the bridge, and master index k+1 is external pair k.

Top module: `sec_bus_arbiter`

## Requirements
- R1: In internal mode exactly one of int_gnt and ext_gnt[N_EXT-1:0] is high on every cycle after reset.
- R2: In internal mode the grant outputs change only at a clock edge where bus_frame and bus_irdy were both low before the edge. At any other edge they hold.
- R3: While reset is held, and on each idle edge in internal mode with no request pending, the grant goes to the bridge: int_gnt=1 and every ext_gnt=0.
- R4: The tier register resets to 1 in bit 0 and 0 in all other bits, so only the bridge is in the high tier. A cfg_wr edge loads cfg_tier, where bit m holds master m's tier (1 = high). The new tiers apply from the next edge.
- R5: The high-tier rotation visits slots in the order master 0 .. master N_EXT, then the low-tier slot (index N_EXT+1), and wraps. Each idle decision grants the first requesting eligible slot at or after the high pointer. The pointer then moves to one past the winning slot.
- R6: When the low-tier slot wins, the low-tier master is the first requesting low-tier master at or after the low pointer, in circular master order. The low pointer then moves past that master, and the high pointer wraps to slot 0.
- R7: Every grant issued by an idle decision in internal mode goes to a master whose request was high at that edge.
- R8: With ext_arb_mode=1, ext_gnt_oe is 1 only in bit 0. ext_gnt[0] follows int_req, int_gnt follows ext_req[0] with no register on the way, and ext_gnt[k] is 0 for k>=1. The internal grant returns to the bridge and both pointers hold.
- R9: With ext_arb_mode=0 every bit of ext_gnt_oe is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Secondary bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_arb_mode | input | 1 | Strap: 1 selects an outside arbiter |
| cfg_wr | input | 1 | Load strobe for the tier register |
| cfg_tier | input | N_EXT+1 | Tier value per master, 1 = high tier |
| bus_frame | input | 1 | Frame asserted on the bus |
| bus_irdy | input | 1 | Initiator ready asserted on the bus |
| int_req | input | 1 | Bridge's own bus request |
| int_gnt | output | 1 | Grant to the bridge |
| ext_req | input | N_EXT | External requests; bit 0 is the outside grant in external mode |
| ext_gnt | output | N_EXT | External grants; bit 0 is the bridge request in external mode |
| ext_gnt_oe | output | N_EXT | Output enable per grant pin |

## Verification
The bench builds the arbiter with the default of nine external pairs. That gives ten masters and an eleven-slot high rotation, whose size is not a power of two, so both pointers must wrap at a non-binary boundary. Nine pairs also leave enough low-tier members to show the low rotation skipping non-requesters and a high-tier master inside the low search. A behavioural model recomputes both rotations every clock under random requests, bus activity, tier rewrites and strap changes, next to hand-worked sequences for each tier and for the external pin reuse.

// File: rtl/sec_arb_pkg.sv
package sec_arb_pkg;
   typedef enum logic {
      ARB_OWN     = 1'b0,
      ARB_OUTSIDE = 1'b1
   } arb_mode_e;

   localparam int BRIDGE_IDX = 0;
endpackage

// File: rtl/arb_rr_pick.sv
module arb_rr_pick #(
   parameter  int W  = 4,
   localparam int IW = (W > 1) ? $clog2(W) : 1
) (
   input  logic [W-1:0]  req,
   input  logic [IW-1:0] ptr,
   output logic          any,
   output logic [IW-1:0] idx
);
   logic [IW:0] kk;

   always_comb begin
      any = 1'b0;
      idx = '0;
      kk  = '0;
      for (int i = 0; i < W; i++) begin
         kk = {1'b0, ptr} + (IW+1)'(i);
         if (kk >= (IW+1)'(W)) kk = kk - (IW+1)'(W);
         if (!any && req[kk[IW-1:0]]) begin
            any = 1'b1;
            idx = kk[IW-1:0];
         end
      end
   end
endmodule

// File: rtl/arb_tier_reg.sv
module arb_tier_reg #(
   parameter int NM = 10
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr,
   input  logic [NM-1:0] wdata,
   output logic [NM-1:0] tier
);
   localparam logic [NM-1:0] TIER_RST = NM'(1);

   always_ff @(posedge clk) begin
      if (!rst_n)  tier <= TIER_RST;
      else if (wr) tier <= wdata;
   end
endmodule

// File: rtl/arb_grant_ctl.sv
module arb_grant_ctl #(
   parameter  int NM = 10,
   localparam int NS = NM + 1,
   localparam int MW = $clog2(NM),
   localparam int SW = $clog2(NS)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          outside,
   input  logic          idle,
   input  logic          any,
   input  logic [SW-1:0] slot_idx,
   input  logic [MW-1:0] lo_idx,
   output logic [SW-1:0] hi_ptr,
   output logic [MW-1:0] lo_ptr,
   output logic [NM-1:0] gnt
);
   localparam logic [NM-1:0] PARK = NM'(1) << sec_arb_pkg::BRIDGE_IDX;

   logic          lo_won;
   logic [MW-1:0] win;
   logic [NM-1:0] gnt_d;

   assign lo_won = (slot_idx == SW'(NM));
   assign win    = lo_won ? lo_idx : slot_idx[MW-1:0];

   always_comb begin
      gnt_d      = '0;
      gnt_d[win] = 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         gnt    <= PARK;
         hi_ptr <= '0;
         lo_ptr <= '0;
      end else if (outside) begin
         gnt <= PARK;
      end else if (idle) begin
         if (any) begin
            gnt    <= gnt_d;
            hi_ptr <= lo_won ? '0 : slot_idx + SW'(1);
            if (lo_won)
               lo_ptr <= (lo_idx == MW'(NM-1)) ? '0 : lo_idx + MW'(1);
         end else begin
            gnt <= PARK;
         end
      end
   end
endmodule

// File: rtl/sec_bus_arbiter.sv
module sec_bus_arbiter #(
   parameter  int N_EXT = 9,
   localparam int NM    = N_EXT + 1,
   localparam int NS    = NM + 1,
   localparam int MW    = $clog2(NM),
   localparam int SW    = $clog2(NS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ext_arb_mode,
   input  logic             cfg_wr,
   input  logic [NM-1:0]    cfg_tier,
   input  logic             bus_frame,
   input  logic             bus_irdy,
   input  logic             int_req,
   output logic             int_gnt,
   input  logic [N_EXT-1:0] ext_req,
   output logic [N_EXT-1:0] ext_gnt,
   output logic [N_EXT-1:0] ext_gnt_oe
);
   import sec_arb_pkg::*;

   if (N_EXT < 1) begin : g_bad_low
      $error("sec_bus_arbiter: N_EXT must be at least 1");
   end
   if (N_EXT > 63) begin : g_bad_high
      $error("sec_bus_arbiter: N_EXT must not exceed 63");
   end

   arb_mode_e     mode;
   logic          outside;
   logic          idle;
   logic [NM-1:0] req_all;
   logic [NM-1:0] tier;
   logic [NM-1:0] lo_vec;
   logic [NS-1:0] slot_vec;
   logic          lo_any;
   logic          hi_any;
   logic [MW-1:0] lo_idx;
   logic [SW-1:0] slot_idx;
   logic [SW-1:0] hi_ptr;
   logic [MW-1:0] lo_ptr;
   logic [NM-1:0] gnt_q;

   assign mode     = arb_mode_e'(ext_arb_mode);
   assign outside  = (mode == ARB_OUTSIDE);
   assign idle     = !bus_frame && !bus_irdy;
   assign req_all  = {ext_req, int_req};
   assign lo_vec   = req_all & ~tier;
   assign slot_vec = {lo_any, req_all & tier};

   arb_tier_reg #(.NM(NM)) u_tier (
      .clk   (clk),
      .rst_n (rst_n),
      .wr    (cfg_wr),
      .wdata (cfg_tier),
      .tier  (tier)
   );

   arb_rr_pick #(.W(NM)) u_lo_pick (
      .req (lo_vec),
      .ptr (lo_ptr),
      .any (lo_any),
      .idx (lo_idx)
   );

   arb_rr_pick #(.W(NS)) u_hi_pick (
      .req (slot_vec),
      .ptr (hi_ptr),
      .any (hi_any),
      .idx (slot_idx)
   );

   arb_grant_ctl #(.NM(NM)) u_ctl (
      .clk      (clk),
      .rst_n    (rst_n),
      .outside  (outside),
      .idle     (idle),
      .any      (hi_any),
      .slot_idx (slot_idx),
      .lo_idx   (lo_idx),
      .hi_ptr   (hi_ptr),
      .lo_ptr   (lo_ptr),
      .gnt      (gnt_q)
   );

   assign int_gnt = outside ? ext_req[0] : gnt_q[BRIDGE_IDX];

   for (genvar k = 0; k < N_EXT; k++) begin : g_pair
      if (k == 0) begin : g_shared
         assign ext_gnt[k]    = outside ? int_req : gnt_q[k+1];
         assign ext_gnt_oe[k] = 1'b1;
      end else begin : g_plain
         assign ext_gnt[k]    = outside ? 1'b0 : gnt_q[k+1];
         assign ext_gnt_oe[k] = !outside;
      end
   end
endmodule

// File: rtl/sec_bus_arbiter_chk.sv
module sec_bus_arbiter_chk #(
   parameter int N_EXT = 9
) (
   input logic             clk,
   input logic             rst_n,
   input logic             ext_arb_mode,
   input logic             bus_frame,
   input logic             bus_irdy,
   input logic             int_req,
   input logic             int_gnt,
   input logic [N_EXT-1:0] ext_req,
   input logic [N_EXT-1:0] ext_gnt,
   input logic [N_EXT-1:0] ext_gnt_oe
);
   // R1
   one_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ext_arb_mode |-> ($countones({ext_gnt, int_gnt}) == 1));

   // R2
   busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ext_arb_mode && (bus_frame || bus_irdy))
      |=> (ext_arb_mode || $stable({ext_gnt, int_gnt})));

   // R3
   park_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ext_arb_mode && !bus_frame && !bus_irdy && !int_req && (ext_req == '0))
      |=> (ext_arb_mode || int_gnt));

   // R7
   won_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ext_arb_mode && !bus_frame && !bus_irdy && (int_req || (ext_req != '0)))
      |=> (ext_arb_mode || (({ext_gnt, int_gnt} & $past({ext_req, int_req})) != '0)));

   // R8
   outside_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ext_arb_mode |-> ((ext_gnt_oe == N_EXT'(1)) && (ext_gnt[0] == int_req)
                        && (int_gnt == ext_req[0])));

   // R9
   own_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ext_arb_mode |-> (ext_gnt_oe == '1));
endmodule

bind sec_bus_arbiter sec_bus_arbiter_chk #(.N_EXT(N_EXT)) u_chk (.*);

// File: tb/sec_bus_arbiter_test.sv
`timescale 1ns/1ps
module sec_bus_arbiter_test;
   localparam int N_EXT = 9;
   localparam int NM    = N_EXT + 1;
   localparam int NS    = NM + 1;
   localparam real HALF = 10.0;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             ext_arb_mode = 1'b0;
   logic             cfg_wr = 1'b0;
   logic [NM-1:0]    cfg_tier = '0;
   logic             bus_frame = 1'b0;
   logic             bus_irdy = 1'b0;
   logic             int_req = 1'b0;
   logic             int_gnt;
   logic [N_EXT-1:0] ext_req = '0;
   logic [N_EXT-1:0] ext_gnt;
   logic [N_EXT-1:0] ext_gnt_oe;

   int tests = 0;
   int fails = 0;
   bit done  = 1'b0;

   always #(HALF) clk = ~clk;

   sec_bus_arbiter #(.N_EXT(N_EXT)) uut (
      .clk(clk), .rst_n(rst_n), .ext_arb_mode(ext_arb_mode),
      .cfg_wr(cfg_wr), .cfg_tier(cfg_tier),
      .bus_frame(bus_frame), .bus_irdy(bus_irdy),
      .int_req(int_req), .int_gnt(int_gnt),
      .ext_req(ext_req), .ext_gnt(ext_gnt), .ext_gnt_oe(ext_gnt_oe)
   );

   // behavioural reference model
   int            m_g, m_hp, m_lp;
   bit [NM-1:0]   m_tier;
   bit [NM-1:0]   m_r;
   bit            m_found;
   int            m_s, m_m;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_g = 0; m_hp = 0; m_lp = 0; m_tier = NM'(1);
      end else begin
         m_r = {ext_req, int_req};
         if (ext_arb_mode) m_g = 0;
         else if (!bus_frame && !bus_irdy) begin
            m_found = 0;
            for (int i = 0; i < NS; i++) begin
               if (!m_found) begin
                  m_s = (m_hp + i) % NS;
                  if (m_s < NM) begin
                     if (m_r[m_s] && m_tier[m_s]) begin
                        m_g = m_s; m_hp = (m_s + 1) % NS; m_found = 1;
                     end
                  end else begin
                     for (int j = 0; j < NM; j++) begin
                        if (!m_found) begin
                           m_m = (m_lp + j) % NM;
                           if (m_r[m_m] && !m_tier[m_m]) begin
                              m_g = m_m; m_lp = (m_m + 1) % NM; m_hp = 0; m_found = 1;
                           end
                        end
                     end
                  end
               end
            end
            if (!m_found) m_g = 0;
         end
         if (cfg_wr) m_tier = cfg_tier;
      end
   end

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic model_cmp(input string tag);
      logic [N_EXT-1:0] e_gnt, e_oe;
      logic             e_int;
      if (ext_arb_mode) begin
         e_oe  = N_EXT'(1);
         e_gnt = N_EXT'(int_req);
         e_int = ext_req[0];
      end else begin
         e_oe  = '1;
         e_int = (m_g == 0);
         e_gnt = '0;
         if (m_g > 0) e_gnt[m_g-1] = 1'b1;
         chk($countones({ext_gnt, int_gnt}) == 1, "R1 single grant",
             32'({ext_gnt, int_gnt}), 32'({e_gnt, e_int}));
      end
      chk({ext_gnt, int_gnt, ext_gnt_oe} == {e_gnt, e_int, e_oe}, tag,
          32'({ext_gnt, int_gnt}), 32'({e_gnt, e_int}));
   endtask

   task automatic tick(input string tag);
      @(posedge clk);
      @(negedge clk);
      model_cmp(tag);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; ext_arb_mode = 1'b0; cfg_wr = 1'b0; cfg_tier = '0;
      bus_frame = 1'b0; bus_irdy = 1'b0; int_req = 1'b0; ext_req = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic expect_ext(input int k, input string tag);
      logic [N_EXT-1:0] e;
      e = '0; e[k] = 1'b1;
      chk(!int_gnt && ext_gnt == e, tag, 32'({ext_gnt, int_gnt}), 32'({e, 1'b0}));
   endtask

   task automatic expect_int(input string tag);
      chk(int_gnt && ext_gnt == '0, tag, 32'({ext_gnt, int_gnt}), 32'(1));
   endtask

   initial begin
      do_reset();
      // reset state, sampled before any edge after release
      expect_int("R3 reset parks on bridge");
      chk(ext_gnt_oe == '1, "R9 enables after reset", 32'(ext_gnt_oe), 32'({N_EXT{1'b1}}));
      tick("R3 idle no requests");
      expect_int("R3 park with no requests");

      // high tier rotation with every master high
      cfg_wr = 1'b1; cfg_tier = '1;
      tick("R4 tier write");
      cfg_wr = 1'b0;
      int_req = 1'b1; ext_req = N_EXT'(9'b000001001);
      tick("R5"); expect_int("R5 first slot bridge");
      tick("R5"); expect_ext(0, "R5 next pair 0");
      tick("R5"); expect_ext(3, "R5 next pair 3");
      tick("R5"); expect_int("R5 wrap to bridge");

      // busy bus holds the grant
      bus_frame = 1'b1;
      tick("R2"); expect_int("R2 hold under frame");
      bus_frame = 1'b0; bus_irdy = 1'b1;
      tick("R2"); expect_int("R2 hold under irdy");
      bus_irdy = 1'b0;
      tick("R2"); expect_ext(0, "R2 moves once idle");

      // default tiers: pairs low, bridge high
      do_reset();
      int_req = 1'b1; ext_req = N_EXT'(2'b11);
      tick("R4"); expect_int("R4 bridge high after reset");
      tick("R6"); expect_ext(0, "R6 low slot pair 0");
      tick("R6"); expect_int("R6 back to bridge");
      tick("R6"); expect_ext(1, "R6 low rotation pair 1");
      tick("R6"); expect_int("R6 bridge again");
      tick("R6"); expect_ext(0, "R6 low wraps to pair 0");
      int_req = 1'b0; ext_req = '0;
      tick("R3"); expect_int("R3 park after requests drop");

      // outside arbiter mode
      ext_arb_mode = 1'b1; int_req = 1'b1; ext_req = '0;
      #1;
      chk(ext_gnt == N_EXT'(1) && !int_gnt, "R8 request out on pair 0", 32'({ext_gnt, int_gnt}), 32'(2));
      chk(ext_gnt_oe == N_EXT'(1), "R8 enables only pair 0", 32'(ext_gnt_oe), 32'(1));
      ext_req = '1;
      #1;
      chk(int_gnt == 1'b1, "R8 outside grant passes in", 32'(int_gnt), 32'(1));
      tick("R8 outside mode");
      int_req = 1'b0;
      tick("R8 outside mode request low");
      ext_arb_mode = 1'b0; ext_req = '0;
      tick("R9 back to own arbiter");
      chk(ext_gnt_oe == '1, "R9 enables restored", 32'(ext_gnt_oe), 32'({N_EXT{1'b1}}));

      // random traffic against the model
      for (int n = 0; n < 4000; n++) begin
         ext_req   = N_EXT'($urandom);
         int_req   = 1'($urandom);
         bus_frame = ($urandom % 3) == 0;
         bus_irdy  = ($urandom % 4) == 0;
         cfg_wr    = ($urandom % 25) == 0;
         cfg_tier  = NM'($urandom);
         if (($urandom % 60) == 0) ext_arb_mode = ~ext_arb_mode;
         tick("R7 model compare");
      end
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      #(2.0 * HALF * 200000.0);
      if (!done) begin
         fails++;
         tests++;
         $display("FAIL R7 watchdog actual=running expected=finished");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end
endmodule